// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block merges three reset requests of a small 8-bit CPU subsystem into one ordered reset sequence. The requests are a low-going pulse on the shared open-drain reset pin, a level from the low-voltage detector and a strobe from the watchdog timer. Whichever request wins starts a delay phase whose length depends on that source. During this phase the block pulls the reset pin low. An oscillator settling count of fixed length follows. The last phase is a two-cycle window in which the CPU is released and reads its reset vector from the two top addresses of its address space.

Any new request during any phase restarts the sequence at the delay phase. A low-voltage level that stays asserted keeps the sequencer in that phase. The pin input is resynchronised, and the block's own pull-down is masked out of it, so the block does not retrigger itself. A sticky one-hot cause register keeps the source of the most recent reset until software reads it.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `rst` is high and after it is released, the sequencer is in the delay phase. `pin_drive_low` is 1, `cpu_rst_n` is 0 and `cause` is 0. This power-on delay lasts LVD_DLY cycles, counted from the first clock edge after `rst` falls.
- R2: A single watchdog strobe holds `pin_drive_low` high for exactly WDG_DLY cycles. A one-cycle low-voltage strobe holds it for exactly LVD_DLY cycles. An external pin pulse holds it for exactly EXT_DLY cycles.
- R3: After the delay phase, `pin_drive_low` is 0 and `cpu_rst_n` stays 0 for exactly STAB_CYC cycles.
- R4: The fetch phase lasts exactly 2 cycles, with `fetch_valid` set to 1. `fetch_addr` is 16'hFFFE in the first cycle and 16'hFFFF in the second. `cpu_rst_n` is 1 from the first fetch cycle onward.
- R5: `seq_done` is a single-cycle pulse in the cycle that follows the second fetch cycle, and occurs once per completed sequence.
- R6: If `lvd_req` is sampled high on H consecutive clock edges, `pin_drive_low` stays high for H + LVD_DLY - 1 cycles.
- R7: A request that arrives in any phase restarts the delay phase, and only one `seq_done` follows.
- R8: A pin low for a single clock edge is detected through a two-flop synchroniser. The block's own drive of the pin does not start another sequence.
- R9: `cause` is one-hot: bit 0 is external, bit 1 is watchdog and bit 2 is low-voltage. It keeps its value until `cause_rd` is high on a clock edge, and reads 0 on the next cycle. A newer reset overwrites it with the newer source.
- R10: If requests coincide on the same edge, low-voltage takes priority over watchdog, and watchdog over external. The delay and the recorded cause both follow the winning source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| pin_in | input | 1 | Sampled level of the shared reset pin, active low |
| lvd_req | input | 1 | Low-voltage detect request, level |
| wdg_req | input | 1 | Watchdog timeout strobe |
| cause_rd | input | 1 | Read strobe that clears the cause register |
| pin_drive_low | output | 1 | Pulls the reset pin low during the delay phase |
| cpu_rst_n | output | 1 | CPU reset, low until the fetch phase begins |
| fetch_valid | output | 1 | High during the two vector fetch cycles |
| fetch_addr | output | 16 | Reset vector byte address during fetch |
| seq_done | output | 1 | One-cycle pulse when the sequence completes |
| cause | output | 3 | Sticky one-hot reset cause {lvd, wdg, ext} |

## Verification
Assertions check on every cycle that a request always forces the delay phase, that the settling counter counts down by one, and that the fetch addresses come in the right order. They also check that the completion pulse follows the second fetch, that the cause register stays one-hot and is cleared by a read, and that low-voltage wins priority. Only the bench scenarios can show the exact length of each phase for each source and the extension while low-voltage is held. They also show the single completion after a restart during settling and that the pin's own drive does not retrigger the sequence through the synchroniser.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;

    typedef enum logic [1:0] {
        PH_DELAY = 2'd0,
        PH_STAB  = 2'd1,
        PH_FETCH = 2'd2,
        PH_RUN   = 2'd3
    } phase_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_EXT  = 2'd1,
        SRC_WDG  = 2'd2,
        SRC_LVD  = 2'd3
    } src_e;

    // bit 2 low-voltage, bit 1 watchdog, bit 0 external
    typedef struct packed {
        logic lvd;
        logic wdg;
        logic ext;
    } cause_t;

    // fixed priority: low-voltage, then watchdog, then external
    function automatic src_e pick_src(input logic lvd, input logic wdg, input logic ext);
        src_e s;
        if (lvd)      s = SRC_LVD;
        else if (wdg) s = SRC_WDG;
        else if (ext) s = SRC_EXT;
        else          s = SRC_NONE;
        return s;
    endfunction

    function automatic cause_t src_to_cause(input src_e s);
        cause_t c;
        c.lvd = (s == SRC_LVD);
        c.wdg = (s == SRC_WDG);
        c.ext = (s == SRC_EXT);
        return c;
    endfunction

endpackage

// File: rtl/rst_pin_sync.sv
module rst_pin_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_in,
    input  logic self_drive,
    output logic ext_req
);
    // pin level and own-drive flag travel through equal-length pipelines,
    // so the mask lines up with the echo of the block's own pull-down
    logic [SYNC_STAGES-1:0] pin_sh;
    logic [SYNC_STAGES-1:0] mask_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_sh  <= '1;
            mask_sh <= '1;
        end else begin
            pin_sh  <= {pin_sh[SYNC_STAGES-2:0], pin_in};
            mask_sh <= {mask_sh[SYNC_STAGES-2:0], self_drive};
        end
    end

    assign ext_req = ~pin_sh[SYNC_STAGES-1] & ~mask_sh[SYNC_STAGES-1];

    // R8: the echo of a fresh self-drive can never be seen as a request
    p_no_self_trigger_r8: assert property (@(posedge clk) disable iff (rst)
        (self_drive && $past(self_drive)) |=> !ext_req);

endmodule

// File: rtl/rst_src_arb.sv
module rst_src_arb
    import rst_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   lvd_req,
    input  logic   wdg_req,
    input  logic   ext_req,
    input  logic   cause_rd,
    output logic   any_req,
    output src_e   win,
    output cause_t cause_q
);
    assign any_req = lvd_req | wdg_req | ext_req;
    assign win     = pick_src(lvd_req, wdg_req, ext_req);

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= '0;
        end else if (any_req) begin
            cause_q <= src_to_cause(win);
        end else if (cause_rd) begin
            cause_q <= '0;
        end
    end

    p_cause_onehot_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cause_q));

    p_read_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (cause_rd && !any_req) |=> (cause_q == '0));

    p_lvd_wins_r10: assert property (@(posedge clk) disable iff (rst)
        lvd_req |=> (cause_q.lvd && !cause_q.wdg && !cause_q.ext));

    p_wdg_over_ext_r10: assert property (@(posedge clk) disable iff (rst)
        (wdg_req && !lvd_req) |=> cause_q.wdg);

endmodule

// File: rtl/rst_phase_fsm.sv
module rst_phase_fsm
    import rst_seq_pkg::*;
#(
    parameter int EXT_DLY  = 4,
    parameter int WDG_DLY  = 32,
    parameter int LVD_DLY  = 64,
    parameter int STAB_CYC = 4096,
    parameter int CNT_W    = 13,
    parameter int ADDR_W   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              any_req,
    input  src_e              win,
    output phase_e            phase,
    output logic              pin_drive_low,
    output logic              cpu_rst_n,
    output logic              fetch_valid,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              seq_done
);
    localparam logic [ADDR_W-1:0] VEC_HI = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] VEC_LO = VEC_HI - 1'b1;

    logic [CNT_W-1:0] cnt;

    function automatic logic [CNT_W-1:0] delay_load(input src_e s);
        logic [CNT_W-1:0] v;
        case (s)
            SRC_LVD: v = CNT_W'(LVD_DLY - 1);
            SRC_WDG: v = CNT_W'(WDG_DLY - 1);
            default: v = CNT_W'(EXT_DLY - 1);
        endcase
        return v;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_DELAY;
            cnt      <= CNT_W'(LVD_DLY - 1);
            seq_done <= 1'b0;
        end else begin
            seq_done <= 1'b0;
            if (any_req) begin
                phase <= PH_DELAY;
                cnt   <= delay_load(win);
            end else begin
                case (phase)
                    PH_DELAY: begin
                        if (cnt == '0) begin
                            phase <= PH_STAB;
                            cnt   <= CNT_W'(STAB_CYC - 1);
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                    PH_STAB: begin
                        if (cnt == '0) begin
                            phase <= PH_FETCH;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                    PH_FETCH: begin
                        if (cnt[0]) begin
                            phase    <= PH_RUN;
                            seq_done <= 1'b1;
                        end else begin
                            cnt <= CNT_W'(1);
                        end
                    end
                    default: begin
                        phase <= PH_RUN;
                    end
                endcase
            end
        end
    end

    assign pin_drive_low = (phase == PH_DELAY);
    assign cpu_rst_n     = (phase == PH_FETCH) || (phase == PH_RUN);
    assign fetch_valid   = (phase == PH_FETCH);
    assign fetch_addr    = (phase != PH_FETCH) ? '0 : (cnt[0] ? VEC_HI : VEC_LO);

    p_req_restart_r7: assert property (@(posedge clk) disable iff (rst)
        any_req |=> (phase == PH_DELAY && pin_drive_low && !cpu_rst_n));

    p_stab_count_r3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_STAB && cnt != '0 && !any_req) |=>
            (phase == PH_STAB && cnt == CNT_W'($past(cnt) - 1'b1)));

    p_fetch_order_r4: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid && fetch_addr == VEC_LO && !any_req) |=>
            (fetch_valid && fetch_addr == VEC_HI));

    p_done_after_fetch_r5: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid && fetch_addr == VEC_HI && !any_req) |=>
            (seq_done && !fetch_valid && cpu_rst_n));

    p_released_in_fetch_r4: assert property (@(posedge clk) disable iff (rst)
        fetch_valid |-> (cpu_rst_n && !pin_drive_low));

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
    import rst_seq_pkg::*;
#(
    parameter int EXT_DLY     = 4,
    parameter int WDG_DLY     = 32,
    parameter int LVD_DLY     = 64,
    parameter int STAB_CYC    = 4096,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pin_in,
    input  logic              lvd_req,
    input  logic              wdg_req,
    input  logic              cause_rd,
    output logic              pin_drive_low,
    output logic              cpu_rst_n,
    output logic              fetch_valid,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              seq_done,
    output logic [2:0]        cause
);
    localparam int MAX_DLY = (LVD_DLY > WDG_DLY) ?
                             ((LVD_DLY > EXT_DLY) ? LVD_DLY : EXT_DLY) :
                             ((WDG_DLY > EXT_DLY) ? WDG_DLY : EXT_DLY);
    localparam int MAX_CNT = (STAB_CYC > MAX_DLY) ? STAB_CYC : MAX_DLY;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);

    logic   ext_req;
    logic   any_req;
    src_e   win;
    cause_t cause_q;
    phase_e phase;
    logic   drive_int;

    rst_pin_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst       (rst),
        .pin_in    (pin_in),
        .self_drive(drive_int),
        .ext_req   (ext_req)
    );

    rst_src_arb u_arb (
        .clk     (clk),
        .rst     (rst),
        .lvd_req (lvd_req),
        .wdg_req (wdg_req),
        .ext_req (ext_req),
        .cause_rd(cause_rd),
        .any_req (any_req),
        .win     (win),
        .cause_q (cause_q)
    );

    rst_phase_fsm #(
        .EXT_DLY (EXT_DLY),
        .WDG_DLY (WDG_DLY),
        .LVD_DLY (LVD_DLY),
        .STAB_CYC(STAB_CYC),
        .CNT_W   (CNT_W),
        .ADDR_W  (ADDR_W)
    ) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .any_req      (any_req),
        .win          (win),
        .phase        (phase),
        .pin_drive_low(drive_int),
        .cpu_rst_n    (cpu_rst_n),
        .fetch_valid  (fetch_valid),
        .fetch_addr   (fetch_addr),
        .seq_done     (seq_done)
    );

    assign pin_drive_low = drive_int;
    assign cause         = cause_q;

    // R2: the pin is pulled low only while the sequencer is in its delay phase
    p_drive_in_delay_r2: assert property (@(posedge clk) disable iff (rst)
        pin_drive_low |-> (phase == PH_DELAY && !cpu_rst_n && !fetch_valid));

    // R6: a held low-voltage level keeps the pin driven
    p_lvd_hold_r6: assert property (@(posedge clk) disable iff (rst)
        lvd_req |=> pin_drive_low);

endmodule

// File: tb/sim_rst_seq_ctrl.sv
module sim_rst_seq_ctrl;

    localparam int EXT_DLY  = 4;
    localparam int WDG_DLY  = 32;
    localparam int LVD_DLY  = 64;
    localparam int STAB_CYC = 4096;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_n = 1'b1;
    logic        lvd_req = 1'b0;
    logic        wdg_req = 1'b0;
    logic        cause_rd = 1'b0;
    logic        pin_in;
    logic        pin_drive_low;
    logic        cpu_rst_n;
    logic        fetch_valid;
    logic [15:0] fetch_addr;
    logic        seq_done;
    logic [2:0]  cause;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    int drv_cnt = 0, stab_cnt = 0, fetch_cnt = 0, done_cnt = 0, bad_rel = 0;
    int fa0 = 0, fa1 = 0;

    always #5 clk = ~clk;

    // open-drain pin: low if either the outside world or the block pulls it
    assign pin_in = ext_n & ~pin_drive_low;

    rst_seq_ctrl u0 (
        .clk          (clk),
        .rst          (rst),
        .pin_in       (pin_in),
        .lvd_req      (lvd_req),
        .wdg_req      (wdg_req),
        .cause_rd     (cause_rd),
        .pin_drive_low(pin_drive_low),
        .cpu_rst_n    (cpu_rst_n),
        .fetch_valid  (fetch_valid),
        .fetch_addr   (fetch_addr),
        .seq_done     (seq_done),
        .cause        (cause)
    );

    always @(negedge clk) begin
        if (pin_drive_low) drv_cnt++;
        if (!cpu_rst_n && !pin_drive_low) stab_cnt++;
        if (fetch_valid) begin
            if (fetch_cnt == 0) fa0 = int'(fetch_addr);
            else fa1 = int'(fetch_addr);
            fetch_cnt++;
            if (!cpu_rst_n) bad_rel++;
        end
        if (seq_done) done_cnt++;
    end

    task automatic summary_and_end();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cyc);
            summary_and_end();
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_meas();
        @(posedge clk);
        #1;
        drv_cnt = 0; stab_cnt = 0; fetch_cnt = 0; done_cnt = 0;
        bad_rel = 0; fa0 = 0; fa1 = 0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (done_cnt != 0) break;
        end
        repeat (4) @(negedge clk);
    endtask

    // mode: 0 ext pulse, 1 wdg, 2 lvd for hold edges, 3 lvd+wdg, 4 wdg+ext
    task automatic apply(input int mode, input int hold);
        @(negedge clk);
        case (mode)
            0: begin ext_n = 1'b0; @(negedge clk); ext_n = 1'b1; end
            1: begin wdg_req = 1'b1; @(negedge clk); wdg_req = 1'b0; end
            2: begin lvd_req = 1'b1; repeat (hold) @(negedge clk); lvd_req = 1'b0; end
            3: begin lvd_req = 1'b1; wdg_req = 1'b1; @(negedge clk);
                     lvd_req = 1'b0; wdg_req = 1'b0; end
            default: begin
                ext_n = 1'b0; @(negedge clk); ext_n = 1'b1;
                @(negedge clk); wdg_req = 1'b1; @(negedge clk); wdg_req = 1'b0;
            end
        endcase
    endtask

    task automatic read_cause();
        @(negedge clk);
        cause_rd = 1'b1;
        @(negedge clk);
        cause_rd = 1'b0;
    endtask

    task automatic chk_tail(input string tag);
        chk("R3", {tag, " settle cycles"}, stab_cnt, STAB_CYC);
        chk("R4", {tag, " fetch cycles"}, fetch_cnt, 2);
        chk("R4", {tag, " first vector addr"}, fa0, 16'hFFFE);
        chk("R4", {tag, " second vector addr"}, fa1, 16'hFFFF);
        chk("R4", {tag, " cpu held in reset during fetch"}, bad_rel, 0);
        chk("R5", {tag, " done pulses"}, done_cnt, 1);
    endtask

    typedef struct packed {
        logic [2:0]  mode;
        logic [7:0]  hold;
        logic [15:0] exp_drv;
        logic [2:0]  exp_cause;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 8'd1,  16'(EXT_DLY),          3'b001},  // R2 R8 ext pulse
        '{3'd1, 8'd1,  16'(WDG_DLY),          3'b010},  // R2 watchdog
        '{3'd2, 8'd1,  16'(LVD_DLY),          3'b100},  // R2 lvd strobe
        '{3'd3, 8'd1,  16'(LVD_DLY),          3'b100},  // R10 lvd beats wdg
        '{3'd4, 8'd1,  16'(WDG_DLY),          3'b010},  // R10 wdg beats ext
        '{3'd2, 8'd10, 16'(10 + LVD_DLY - 1), 3'b100}   // R6 lvd held
    };

    initial begin
        // R1: power-on
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        drv_cnt = 0; stab_cnt = 0; fetch_cnt = 0; done_cnt = 0; bad_rel = 0;
        @(negedge clk);
        chk("R1", "drive after reset", int'(pin_drive_low), 1);
        chk("R1", "cpu_rst_n after reset", int'(cpu_rst_n), 0);
        chk("R1", "cause after reset", int'(cause), 0);
        wait_done();
        chk("R1", "power-on delay cycles", drv_cnt, LVD_DLY);
        chk_tail("por");

        // table walk
        for (int v = 0; v < NV; v++) begin
            clear_meas();
            apply(int'(VECS[v].mode), int'(VECS[v].hold));
            wait_done();
            chk("R2", $sformatf("vec%0d delay cycles", v), drv_cnt, int'(VECS[v].exp_drv));
            chk("R10", $sformatf("vec%0d cause", v), int'(cause), int'(VECS[v].exp_cause));
            chk_tail($sformatf("vec%0d", v));
            read_cause();
            chk("R9", $sformatf("vec%0d cause after read", v), int'(cause), 0);
        end

        // R8: own drive does not retrigger; pin stays idle long after
        clear_meas();
        apply(0, 1);
        wait_done();
        repeat (40) @(negedge clk);
        chk("R8", "no retrigger drive cycles", drv_cnt, EXT_DLY);
        chk("R8", "no retrigger done count", done_cnt, 1);
        chk("R8", "cpu stays released", int'(cpu_rst_n), 1);

        // R9: sticky over many cycles, then overwritten by a newer source
        repeat (20) @(negedge clk);
        chk("R9", "cause sticky without read", int'(cause), 3'b001);
        clear_meas();
        apply(1, 1);
        wait_done();
        chk("R9", "newer source overwrites cause", int'(cause), 3'b010);
        read_cause();
        chk("R9", "cleared by read", int'(cause), 0);

        // R7: restart during the settling phase
        clear_meas();
        apply(1, 1);
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (stab_cnt >= 100) break;
        end
        apply(1, 1);
        wait_done();
        chk("R7", "restart drive cycles", drv_cnt, 2 * WDG_DLY);
        chk("R7", "restart done count", done_cnt, 1);
        chk("R7", "restart fetch cycles", fetch_cnt, 2);

        // R7: restart during fetch window via lvd
        clear_meas();
        apply(1, 1);
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            if (fetch_cnt == 1) break;
        end
        lvd_req = 1'b1;
        @(negedge clk);
        lvd_req = 1'b0;
        chk("R7", "drive after restart in fetch", int'(pin_drive_low), 1);
        chk("R7", "cpu back in reset", int'(cpu_rst_n), 0);
        wait_done();
        chk("R7", "fetch restart done count", done_cnt, 1);
        chk("R10", "fetch restart cause", int'(cause), 3'b100);

        summary_and_end();
    end

endmodule